// File: doc/BRIEF.md
# Interrupt Enable and Debug-Halt Qualifier

This block holds the two 16-bit enable masks that decide which of sixteen level-sensitive interrupt requests may be taken by the CPU. One is the ordinary interrupt enable mask. The other is a debug enable mask, and it only matters while the CPU is stopped in real-time debug. Software reaches the ordinary mask through a small register port. That port supports a full load, a bitwise clear through an AND mask, and a bitwise set through an OR mask. The debug mask has its own load strobe. Both masks can be read back at all times.

From the two masks, the pending lines and a halt flag, the block forms a qualified request vector. While the CPU runs, a request qualifies when its ordinary enable bit is set, and the debug mask has no effect. While the CPU is halted in real-time debug, a request qualifies only when it is enabled in both masks. A fixed-priority picker then reports the lowest qualified bit position as an index, together with a valid flag. The bit layout is as follows. Bit x-1 belongs to general interrupt x, for x = 1 to 14. Bit 14 is the data-logging interrupt and bit 15 is the real-time kernel interrupt.

The update command is decoded into one of four named operations: OP_IDLE, OP_LOAD, OP_CLEAR and OP_SET. The CPU context is one of two named modes: MODE_RUN (cpu_halted = 0) and MODE_HALT (cpu_halted = 1). The CPU context can switch between these two modes on any cycle.

Top module: `irq_gate_top`

## Requirements
- R1: After reset, both masks read 0, irq_qual is 0, irq_valid is 0 and irq_index is 0.
- R2: When en_wr is 1 at a rising edge, en_rdata equals en_wdata from that edge on.
- R3: When en_and is 1 and en_wr is 0 at a rising edge, the ordinary mask becomes its old value AND en_wdata.
- R4: When en_or is 1 and both en_wr and en_and are 0 at a rising edge, the ordinary mask becomes its old value OR en_wdata.
- R5: Simultaneous strobes resolve as follows. en_wr wins over en_and, and en_and wins over en_or. With no strobe, the mask is unchanged.
- R6: When dbg_wr is 1 at a rising edge, dbg_rdata equals dbg_wdata from that edge on.
- R7: When cpu_halted is 0, irq_qual equals irq_pend AND the ordinary mask, whatever the debug mask holds.
- R8: When cpu_halted is 1, irq_qual equals irq_pend AND the ordinary mask AND the debug mask.
- R9: When any bit of irq_qual is 1, irq_valid is 1 and irq_index is the lowest set bit position. Bit 0 (INT1) has the highest priority and bit 15 (the real-time kernel interrupt) has the lowest.
- R10: When no bit of irq_qual is 1, irq_valid is 0 and irq_index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Full load strobe for the ordinary mask |
| en_and | input | 1 | AND-mask strobe for the ordinary mask |
| en_or | input | 1 | OR-mask strobe for the ordinary mask |
| en_wdata | input | 16 | Data or mask for ordinary-mask updates |
| dbg_wr | input | 1 | Load strobe for the debug mask |
| dbg_wdata | input | 16 | Data for the debug mask |
| en_rdata | output | 16 | Current ordinary mask |
| dbg_rdata | output | 16 | Current debug mask |
| irq_pend | input | 16 | Level pending request lines |
| cpu_halted | input | 1 | 1 while the CPU is halted in real-time debug |
| irq_qual | output | 16 | Qualified requests |
| irq_valid | output | 1 | At least one request qualifies |
| irq_index | output | 4 | Bit position of the highest-priority qualified request |

## Verification
Several things can land in the same cycle, and the bench provokes each one on purpose:

- **Competing mask updates.** A full load, an AND and an OR can all be strobed on the same edge. The bench raises these strobes in every combination of two or three, with data chosen so that each possible winner leaves a different value. The read-back then shows which one took effect.
- **Mask update against qualification.** In the cycle a mask is updated, qualification must still use the old mask. Both the qualified vector and the picked index must follow the new mask only after the edge. The bench holds the pending lines steady across an update and samples the outputs just before and just after that edge.
- **Halt toggling.** With the debug mask deliberately different from the ordinary one, cpu_halted is toggled. The bench then confirms that the qualified vector switches at once between the one-mask and two-mask rules.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_SET   = 2'd3
    } upd_op_e;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_HALT = 1'b1
    } cpu_mode_e;

endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs
    import irq_gate_pkg::*;
#(
    parameter int N_IRQ = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_and,
    input  logic             en_or,
    input  logic [N_IRQ-1:0] en_wdata,
    input  logic             dbg_wr,
    input  logic [N_IRQ-1:0] dbg_wdata,
    output logic [N_IRQ-1:0] en_mask,
    output logic [N_IRQ-1:0] dbg_mask
);

    upd_op_e          op;
    logic [N_IRQ-1:0] en_next;

    // Strobe decode: load beats clear beats set.
    always_comb begin
        if (en_wr)       op = OP_LOAD;
        else if (en_and) op = OP_CLEAR;
        else if (en_or)  op = OP_SET;
        else             op = OP_IDLE;
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  en_next = en_wdata;
            OP_CLEAR: en_next = en_mask & en_wdata;
            OP_SET:   en_next = en_mask | en_wdata;
            default:  en_next = en_mask;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else begin
            en_mask <= en_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_mask <= '0;
        end else if (dbg_wr) begin
            dbg_mask <= dbg_wdata;
        end
    end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_gate_pkg::*;
#(
    parameter int N_IRQ = 16
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] en_mask,
    input  logic [N_IRQ-1:0] dbg_mask,
    input  logic             cpu_halted,
    output logic [N_IRQ-1:0] irq_qual
);

    cpu_mode_e mode;

    assign mode = cpu_halted ? MODE_HALT : MODE_RUN;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
        logic dbg_ok;
        always_comb begin
            unique case (mode)
                MODE_HALT: dbg_ok = dbg_mask[g];
                default:   dbg_ok = 1'b1;
            endcase
        end
        assign irq_qual[g] = irq_pend[g] & en_mask[g] & dbg_ok;
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_IRQ = 16,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] irq_qual,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_index
);

    // Scan from the top down so the lowest set position is the last assignment.
    always_comb begin
        irq_valid = 1'b0;
        irq_index = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (irq_qual[i]) begin
                irq_valid = 1'b1;
                irq_index = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top #(
    parameter int N_IRQ = 16,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_and,
    input  logic             en_or,
    input  logic [N_IRQ-1:0] en_wdata,
    input  logic             dbg_wr,
    input  logic [N_IRQ-1:0] dbg_wdata,
    output logic [N_IRQ-1:0] en_rdata,
    output logic [N_IRQ-1:0] dbg_rdata,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic             cpu_halted,
    output logic [N_IRQ-1:0] irq_qual,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_index
);

    logic [N_IRQ-1:0] en_mask;
    logic [N_IRQ-1:0] dbg_mask;

    irq_en_regs #(.N_IRQ(N_IRQ)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_and   (en_and),
        .en_or    (en_or),
        .en_wdata (en_wdata),
        .dbg_wr   (dbg_wr),
        .dbg_wdata(dbg_wdata),
        .en_mask  (en_mask),
        .dbg_mask (dbg_mask)
    );

    irq_qualify #(.N_IRQ(N_IRQ)) u_qual (
        .irq_pend  (irq_pend),
        .en_mask   (en_mask),
        .dbg_mask  (dbg_mask),
        .cpu_halted(cpu_halted),
        .irq_qual  (irq_qual)
    );

    irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
        .irq_qual (irq_qual),
        .irq_valid(irq_valid),
        .irq_index(irq_index)
    );

    assign en_rdata  = en_mask;
    assign dbg_rdata = dbg_mask;

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int N_IRQ = 16,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_wr,
    input logic             en_and,
    input logic             en_or,
    input logic [N_IRQ-1:0] en_wdata,
    input logic             dbg_wr,
    input logic [N_IRQ-1:0] dbg_wdata,
    input logic [N_IRQ-1:0] en_rdata,
    input logic [N_IRQ-1:0] dbg_rdata,
    input logic [N_IRQ-1:0] irq_pend,
    input logic             cpu_halted,
    input logic [N_IRQ-1:0] irq_qual,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_index
);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> en_rdata == $past(en_wdata)); // R2

    AST_CLEAR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr && en_and) |=> en_rdata == ($past(en_rdata) & $past(en_wdata))); // R3

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr && !en_and && en_or) |=> en_rdata == ($past(en_rdata) | $past(en_wdata))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr && !en_and && !en_or) |=> $stable(en_rdata)); // R5

    AST_DBG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_wr |=> dbg_rdata == $past(dbg_wdata)); // R6

    AST_RUN_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_halted |-> irq_qual == (irq_pend & en_rdata)); // R7

    AST_HALT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halted |-> irq_qual == (irq_pend & en_rdata & dbg_rdata)); // R8

    AST_PICK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_qual[irq_index]); // R9

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_qual & ((N_IRQ'(1) << irq_index) - N_IRQ'(1))) == '0); // R9

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_qual == '0) |-> (!irq_valid && irq_index == '0)); // R10

endmodule

bind irq_gate_top irq_gate_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/test_irq_gate_top.sv
module test_irq_gate_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0, en_and = 1'b0, en_or = 1'b0, dbg_wr = 1'b0;
    logic [15:0] en_wdata = '0, dbg_wdata = '0, irq_pend = '0;
    logic        cpu_halted = 1'b0;
    logic [15:0] en_rdata, dbg_rdata, irq_qual;
    logic        irq_valid;
    logic [3:0]  irq_index;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_gate_top i_irq_gate_top (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Expected qualification and pick, computed from the requirements.
    task automatic chk_out(input string tag, input logic [15:0] en_m, input logic [15:0] dbg_m);
        logic [15:0] q;
        logic        v;
        logic [3:0]  ix;
        q = cpu_halted ? (irq_pend & en_m & dbg_m) : (irq_pend & en_m);
        v = 1'b0;
        ix = 4'd0;
        for (int i = 0; i < 16; i++) begin
            if (q[i] && !v) begin
                v = 1'b1;
                ix = 4'(i);
            end
        end
        chk({tag, " qual"}, 32'(irq_qual), 32'(q));
        chk({tag, " valid"}, 32'(irq_valid), 32'(v));
        chk({tag, " index"}, 32'(irq_index), 32'(ix));
    endtask

    // Apply strobes for one edge; inputs change on the falling edge.
    task automatic strobe(input logic w, input logic a, input logic o, input logic [15:0] d);
        @(negedge clk);
        en_wr = w; en_and = a; en_or = o; en_wdata = d;
        @(negedge clk);
        en_wr = 1'b0; en_and = 1'b0; en_or = 1'b0;
    endtask

    task automatic load_dbg(input logic [15:0] d);
        @(negedge clk);
        dbg_wr = 1'b1; dbg_wdata = d;
        @(negedge clk);
        dbg_wr = 1'b0;
    endtask

    task automatic t_reset;
        irq_pend = 16'hFFFF;
        #1;
        chk("R1 en", 32'(en_rdata), 32'h0);
        chk("R1 dbg", 32'(dbg_rdata), 32'h0);
        chk("R1 valid", 32'(irq_valid), 32'h0);
        chk("R1 index", 32'(irq_index), 32'h0);
        chk("R1 qual", 32'(irq_qual), 32'h0);
        irq_pend = '0;
    endtask

    task automatic t_load;
        strobe(1'b1, 1'b0, 1'b0, 16'hA5C3);
        chk("R2 load", 32'(en_rdata), 32'hA5C3);
    endtask

    task automatic t_clear;
        strobe(1'b0, 1'b1, 1'b0, 16'hFF0F);
        chk("R3 and", 32'(en_rdata), 32'hA503);
    endtask

    task automatic t_set;
        strobe(1'b0, 1'b0, 1'b1, 16'h0070);
        chk("R4 or", 32'(en_rdata), 32'hA573);
    endtask

    task automatic t_collide;
        strobe(1'b1, 1'b1, 1'b1, 16'h3C00);
        chk("R5 all three", 32'(en_rdata), 32'h3C00);
        strobe(1'b0, 1'b1, 1'b1, 16'h0C0F);
        chk("R5 and over or", 32'(en_rdata), 32'h0C00);
        strobe(1'b1, 1'b0, 1'b1, 16'h1234);
        chk("R5 load over or", 32'(en_rdata), 32'h1234);
        strobe(1'b1, 1'b1, 1'b0, 16'h4321);
        chk("R5 load over and", 32'(en_rdata), 32'h4321);
        @(negedge clk);
        @(negedge clk);
        chk("R5 idle holds", 32'(en_rdata), 32'h4321);
    endtask

    task automatic t_dbg;
        load_dbg(16'h00F0);
        chk("R6 dbg load", 32'(dbg_rdata), 32'h00F0);
        chk("R6 en untouched", 32'(en_rdata), 32'h4321);
    endtask

    task automatic t_run;
        strobe(1'b1, 1'b0, 1'b0, 16'hFF0C);
        cpu_halted = 1'b0;
        irq_pend = 16'hFFFF;
        #1 chk_out("R7 run all pend", 16'hFF0C, 16'h00F0);
        irq_pend = 16'h8008;
        #1 chk_out("R7 run dbg ignored", 16'hFF0C, 16'h00F0);
        chk("R7 run qual", 32'(irq_qual), 32'h8008);
    endtask

    task automatic t_halt;
        load_dbg(16'h4F08);
        cpu_halted = 1'b1;
        irq_pend = 16'hFFFF;
        #1 chk_out("R8 halt both", 16'hFF0C, 16'h4F08);
        chk("R8 halt qual", 32'(irq_qual), 32'h4F08);
        irq_pend = 16'h8004;
        #1 chk("R8 halt blocked", 32'(irq_valid), 32'h0);
        cpu_halted = 1'b0;
        #1 chk("R8 back to run", 32'(irq_index), 32'h2);
    endtask

    task automatic t_prio;
        cpu_halted = 1'b0;
        strobe(1'b1, 1'b0, 1'b0, 16'hFFFF);
        irq_pend = 16'h8000;
        #1 chk("R9 only rtos", 32'(irq_index), 32'hF);
        chk("R9 only rtos valid", 32'(irq_valid), 32'h1);
        irq_pend = 16'hC001;
        #1 chk("R9 INT1 wins", 32'(irq_index), 32'h0);
        irq_pend = 16'h4810;
        #1 chk("R9 mid pick", 32'(irq_index), 32'h4);
        // Update in flight: old mask applies until the edge.
        @(negedge clk);
        en_and = 1'b1; en_wdata = 16'hFFEF;
        #1 chk("R9 old mask before edge", 32'(irq_index), 32'h4);
        @(negedge clk);
        en_and = 1'b0;
        chk("R9 new mask after edge", 32'(irq_index), 32'hB);
    endtask

    task automatic t_none;
        irq_pend = 16'h0010;
        #1 chk("R10 none valid", 32'(irq_valid), 32'h0);
        chk("R10 none index", 32'(irq_index), 32'h0);
        irq_pend = 16'h0000;
        #1 chk("R10 no pend", 32'(irq_valid), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_load();
        t_clear();
        t_set();
        t_collide();
        t_dbg();
        t_run();
        t_halt();
        t_prio();
        t_none();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule